// File: doc/BRIEF.md
# Dual Programmable Interval Timer

The block holds two independent interval timers behind a small 32-bit register bus. Each timer has a control word, a load value and a live counter. Software writes a start value into the load register and sets the load-hold bit, which copies that value into the counter. It then clears load-hold and sets the run bit. From then on the counter steps by one on every clock, down or up as the direction bit selects.

When a counter steps onto its terminal value, the timer's status flag is set and stays set. With auto-reload on, the counter takes the load value again on the next clock and keeps counting. With auto-reload off, the counter stays at the terminal value. One interrupt line collects the flags of the timers whose interrupt enable is set. Writing the control word back with the status bit set acknowledges the interrupt. A start-both bit lets a single write set the run bit of both timers.

Top module: `dual_timer`

## Requirements
- R1: After reset every control field, load register, counter and status flag is 0, and `irq` is 0.
- R2: Word address bit 2 selects the timer. Address bits 1:0 select the control word (0), the load register (1) or the counter (2); index 3 reads 0. Control word bits: 1 count down, 4 auto-reload, 5 load-hold, 6 interrupt enable, 7 run, 8 status, 10 start-both. Every other bit, and bit 10 itself, reads 0. Bus reads are combinational.
- R3: While load-hold reads 1, the counter takes the load register value on every clock and does not count.
- R4: With run set and load-hold clear, the counter decrements by 1 per clock if the down bit is 1 and increments by 1 if it is 0.
- R5: The terminal value is 0 when counting down and all ones when counting up. Status is set on the clock edge on which the counter steps onto the terminal value.
- R6: With auto-reload set, a running counter that sits at the terminal value takes the load value on the next clock and goes on counting.
- R7: With auto-reload clear, a running counter at the terminal value stays there.
- R8: A control write with bit 8 = 1 clears status, and a write with bit 8 = 0 leaves it unchanged. A hardware set on the same clock wins over the clear.
- R9: Clearing the run bit freezes the counter at its current value.
- R10: `irq` is the OR over both timers of status AND interrupt enable. A timer with interrupt enable clear still counts and still sets its status.
- R11: A control write with bit 10 = 1 to either timer sets the run bit of both timers.
- R12: Writes to a counter address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The counters run through several patterns. A short down-count with auto-reload shows the step direction, the terminal value and the reload timing. An up-count loaded just below all ones without auto-reload checks the hold at the terminal value and shows that a masked timer still sets its flag. Acknowledge writes are issued every cycle while a short period runs, so a clear eventually lands on the same edge as a set, which tests the set-over-clear rule. A freeze, a write to the counter address and a start-both write show that the count does not move and that the run bits change together. The bench checks the combinational read data and the interrupt against its model on every clock.

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int NCH    = 2;
  localparam int B_DOWN = 1;
  localparam int B_ARLD = 4;
  localparam int B_LDH  = 5;
  localparam int B_IE   = 6;
  localparam int B_RUN  = 7;
  localparam int B_STS  = 8;
  localparam int B_ALL  = 10;

  logic [NCH-1:0][CNT_W-1:0] cnt_q, ldv_q;
  logic [NCH-1:0][31:0]      ctl_w;
  logic [NCH-1:0]            sts_q, ie_q, en_q, ldh_q, down_q;

  wire all_wr = reg_we && reg_addr[1:0] == 2'd0 && reg_wdata[B_ALL];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic             down, arld, ldh, ie, en, sts;
    logic [CNT_W-1:0] ldv, cnt;

    wire              sel    = reg_we && reg_addr[2] == c[0];
    wire              ctl_wr = sel && reg_addr[1:0] == 2'd0;
    wire              ldv_wr = sel && reg_addr[1:0] == 2'd1;
    wire [CNT_W-1:0]  tc     = down ? '0 : '1;
    wire              at_tc  = cnt == tc;
    wire [CNT_W-1:0]  step   = down ? cnt - 1'b1 : cnt + 1'b1;
    wire              counting = en && !ldh && !at_tc;
    wire              reload   = en && !ldh && at_tc && arld;
    wire              hit      = counting && step == tc;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        down <= 1'b0;
        arld <= 1'b0;
        ldh  <= 1'b0;
        ie   <= 1'b0;
        en   <= 1'b0;
        sts  <= 1'b0;
        ldv  <= '0;
        cnt  <= '0;
      end else begin
        if (ctl_wr) begin
          down <= reg_wdata[B_DOWN];
          arld <= reg_wdata[B_ARLD];
          ldh  <= reg_wdata[B_LDH];
          ie   <= reg_wdata[B_IE];
          en   <= reg_wdata[B_RUN];
        end
        if (all_wr) en <= 1'b1;
        if (ldv_wr) ldv <= reg_wdata[CNT_W-1:0];
        if (hit) sts <= 1'b1;
        else if (ctl_wr && reg_wdata[B_STS]) sts <= 1'b0;
        if (ldh) cnt <= ldv;
        else if (counting) cnt <= step;
        else if (reload) cnt <= ldv;
      end
    end

    always_comb begin
      ctl_w[c]         = '0;
      ctl_w[c][B_DOWN] = down;
      ctl_w[c][B_ARLD] = arld;
      ctl_w[c][B_LDH]  = ldh;
      ctl_w[c][B_IE]   = ie;
      ctl_w[c][B_RUN]  = en;
      ctl_w[c][B_STS]  = sts;
    end

    assign cnt_q[c]  = cnt;
    assign ldv_q[c]  = ldv;
    assign sts_q[c]  = sts;
    assign ie_q[c]   = ie;
    assign en_q[c]   = en;
    assign ldh_q[c]  = ldh;
    assign down_q[c] = down;
  end

  wire ch = reg_addr[2];

  always_comb begin
    case (reg_addr[1:0])
      2'd0:    reg_rdata = ctl_w[ch];
      2'd1:    reg_rdata = 32'(ldv_q[ch]);
      2'd2:    reg_rdata = 32'(cnt_q[ch]);
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(sts_q & ie_q);
endmodule

// File: rtl/dual_timer_props.sv
module dual_timer_props #(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            reg_addr,
  input logic                  reg_we,
  input logic [31:0]           reg_wdata,
  input logic                  irq,
  input logic [1:0][CNT_W-1:0] cnt_q,
  input logic [1:0][CNT_W-1:0] ldv_q,
  input logic [1:0]            sts_q,
  input logic [1:0]            en_q,
  input logic [1:0]            ldh_q,
  input logic [1:0]            down_q
);
  p_hold_load0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ldh_q[0] |=> cnt_q[0] == $past(ldv_q[0]));
  p_hold_load1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ldh_q[1] |=> cnt_q[1] == $past(ldv_q[1]));
  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[0] && !ldh_q[0] && down_q[0] && cnt_q[0] != '0) |=> cnt_q[0] == $past(cnt_q[0]) - 1'b1);
  p_tc_on_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[0]) |-> (cnt_q[0] == '0 || cnt_q[0] == '1));
  p_sticky0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[0] && !(reg_we && reg_addr == 3'd0 && reg_wdata[8])) |=> sts_q[0]);
  p_sticky1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[1] && !(reg_we && reg_addr == 3'd4 && reg_wdata[8])) |=> sts_q[1]);
  p_freeze0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] && !ldh_q[0]) |=> $stable(cnt_q[0]));
  p_freeze1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[1] && !ldh_q[1]) |=> $stable(cnt_q[1]));
  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_q != 2'b00);
  p_start_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[1:0] == 2'd0 && reg_wdata[10]) |=> en_q == 2'b11);
endmodule

bind dual_timer dual_timer_props #(.CNT_W(CNT_W)) u_props (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .irq(irq), .cnt_q(cnt_q), .ldv_q(ldv_q),
  .sts_q(sts_q), .en_q(en_q), .ldh_q(ldh_q), .down_q(down_q)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  dual_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  bit [31:0] m_cnt [2];
  bit [31:0] m_ldv [2];
  bit        m_down[2], m_arld[2], m_ldh[2], m_ie[2], m_en[2], m_sts[2];

  always @(posedge clk) begin
    bit [31:0] n_cnt [2];
    bit        n_sts [2];
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_ldv[c] = 0; m_down[c] = 0; m_arld[c] = 0;
        m_ldh[c] = 0; m_ie[c] = 0; m_en[c] = 0; m_sts[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit [31:0] term;
        bit        reached;
        term = m_down[c] ? 32'd0 : 32'hFFFF_FFFF;
        reached = 0;
        n_cnt[c] = m_cnt[c];
        if (m_ldh[c]) n_cnt[c] = m_ldv[c];
        else if (m_en[c]) begin
          if (m_cnt[c] != term) begin
            n_cnt[c] = m_down[c] ? m_cnt[c] - 1 : m_cnt[c] + 1;
            reached = (n_cnt[c] == term);
          end else if (m_arld[c]) n_cnt[c] = m_ldv[c];
        end
        if (reached) n_sts[c] = 1;
        else if (we && addr == 3'(c * 4) && wdata[8]) n_sts[c] = 0;
        else n_sts[c] = m_sts[c];
      end
      for (int c = 0; c < 2; c++) begin
        if (we && int'(addr[2]) == c && addr[1:0] == 2'd0) begin
          m_down[c] = wdata[1]; m_arld[c] = wdata[4]; m_ldh[c] = wdata[5];
          m_ie[c] = wdata[6]; m_en[c] = wdata[7];
        end
        if (we && int'(addr[2]) == c && addr[1:0] == 2'd1) m_ldv[c] = wdata;
      end
      if (we && addr[1:0] == 2'd0 && wdata[10]) begin
        m_en[0] = 1; m_en[1] = 1;
      end
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = n_cnt[c];
        m_sts[c] = n_sts[c];
      end
    end
  end

  function automatic bit [31:0] exp_rdata(input bit [2:0] a);
    int c = int'(a[2]);
    case (a[1:0])
      2'd0: return {21'd0, 2'b00, m_sts[c], m_en[c], m_ie[c], m_ldh[c],
                    m_arld[c], 2'b00, m_down[c], 1'b0};
      2'd1: return m_ldv[c];
      2'd2: return m_cnt[c];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check_now();
    bit [31:0] er = exp_rdata(addr);
    bit        ei = (m_sts[0] & m_ie[0]) | (m_sts[1] & m_ie[1]);
    vectors++;
    if (rdata !== er || irq !== ei) begin
      fails++;
      $display("FAIL %s addr=%0d rdata=%h exp=%h irq=%b exp=%b",
               cur_req, addr, rdata, er, irq, ei);
    end
  endtask

  task automatic cyc(input bit [2:0] a, input bit w, input bit [31:0] d);
    @(negedge clk);
    check_now();
    #1;
    addr = a; we = w; wdata = d;
  endtask

  task automatic idle(input bit [2:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(a, 1'b0, 32'd0);
  endtask

  localparam bit [31:0] DOWN = 32'h002, ARLD = 32'h010, LDH = 32'h020,
                        IE = 32'h040, RUN = 32'h080, STS = 32'h100, ALL = 32'h400;

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 32'd0);

    cur_req = "R2";
    cyc(3'd1, 1'b1, 32'd5);
    cyc(3'd5, 1'b1, 32'hFFFF_FFFA);
    cyc(3'd0, 1'b1, 32'hFFFF_FE2D);
    for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 32'd0);

    cur_req = "R3";
    cyc(3'd0, 1'b1, LDH | DOWN);
    idle(3'd2, 3);

    cur_req = "R4";
    cyc(3'd0, 1'b1, DOWN | ARLD | IE | RUN);
    idle(3'd2, 3);
    cur_req = "R5";
    idle(3'd2, 3);
    cur_req = "R6";
    idle(3'd2, 6);
    cur_req = "R10";
    idle(3'd0, 2);

    cur_req = "R8";
    cyc(3'd0, 1'b1, DOWN | ARLD | IE | RUN);
    idle(3'd0, 2);
    cyc(3'd0, 1'b1, DOWN | ARLD | IE | RUN | STS);
    idle(3'd0, 2);
    cyc(3'd1, 1'b1, 32'd2);
    for (int i = 0; i < 12; i++) cyc(3'd0, 1'b1, DOWN | ARLD | IE | RUN | STS);
    idle(3'd0, 2);

    cur_req = "R9";
    cyc(3'd0, 1'b1, DOWN | ARLD | IE | STS);
    idle(3'd2, 4);

    cur_req = "R7";
    cyc(3'd4, 1'b1, LDH);
    cyc(3'd4, 1'b1, RUN);
    idle(3'd6, 10);
    cur_req = "R10";
    idle(3'd4, 2);
    cyc(3'd4, 1'b1, RUN | IE);
    idle(3'd4, 2);
    cyc(3'd4, 1'b1, RUN | IE | STS);
    idle(3'd4, 2);

    cur_req = "R12";
    cyc(3'd2, 1'b1, 32'h1234_5678);
    cyc(3'd6, 1'b1, 32'h0000_0003);
    idle(3'd2, 2);
    idle(3'd6, 2);

    cur_req = "R11";
    cyc(3'd4, 1'b1, LDH);
    cyc(3'd5, 1'b1, 32'd100);
    cyc(3'd4, 1'b1, ALL);
    idle(3'd0, 2);
    idle(3'd4, 2);
    idle(3'd2, 4);
    idle(3'd6, 4);

    cur_req = "R1";
    cyc(3'd0, 1'b0, 32'd0);
    rst_n = 1'b0;
    idle(3'd0, 2);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule